// File: doc/BRIEF.md
# CD Subcode Port Timing Controller

This block drives the subcode side port of a digital audio transmitter while the transmitter runs in its CD submode. In each audio frame it sends a framing strobe (SBF) and then one cycle of a subcode bit clock (SBC) to an external subcode source. It samples the symbol that source returns on the serial user-data input. At the start of each subcode block it stretches the framing strobe well beyond its normal length, so the source knows a new block has begun. The first, third and fourth Q bits after that start are collected and passed on as channel status bits 5, 2 and 3.

The block runs on a single clock `clk` at twice the serial bit-clock rate, so one clock cycle is half an SCK period. The frame sync input is sampled in this domain, and its rising edge is taken as the active frame edge. The port is active only when consumer mode is selected and both frequency-code inputs are high. Otherwise it stays silent and restarts its block count.

Top module: `cd_subcode_port`

## Requirements
- R1: `sbc` is never high while `sbf` is high. In every frame, `sbc` goes high in the cycle in which `sbf` falls, stays high for 2 cycles (one SCK) and is then low for 2 cycles before the port goes idle.
- R2: In a frame that is not a block start, `sbf` is high for exactly 2 consecutive cycles (one SCK period).
- R3: When `fmtSel` is any value other than 3'd4, `sbf` is high in the first cycle after the clock edge at which an idle port samples a rising `fsync`.
- R4: When `fmtSel` is 3'd4, `sbf` stays low for 2 cycles after that edge and goes high in the third cycle, which is one SCK period later than in R3.
- R5: A frame is a block start if it is the first frame after enable or reset, or if `BLOCK_SYMS` (default 98) SBC pulses have been issued since the previous block start. In a block start, `sbf` is held high for `HOLD_SBC` SBC periods (default 17 periods = 68 cycles) in place of 2 cycles.
- R6: `subIn` is sampled at the clock edge at which `sbc` rises. `subBit` shows the sampled value, and `subStrobe` is high for exactly the one cycle that follows that edge.
- R7: The symbols sampled first, third and fourth after a block start are driven on `csBit5`, `csBit2` and `csBit3`. All three change together, on the edge at which the fourth symbol is sampled, and at no other edge.
- R8: The port is enabled only when `consumerMode` is 1 and `freqCode` is 2'b11. While it is disabled, `sbf` and `sbc` are low one cycle later and frame edges are ignored. Re-enabling makes the next frame a block start. `csBit*` and `subBit` keep their values while the port is disabled.
- R9: A synchronous reset drives `sbf`, `sbc`, `subBit`, `subStrobe` and all `csBit*` to 0 and returns the port to idle.
- R10: A rising `fsync` that arrives while a frame's strobe or clock sequence is still running is ignored. This includes the last cycle of that sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the SCK rate |
| rst | input | 1 | Synchronous reset, active high |
| consumerMode | input | 1 | Consumer mode select |
| freqCode | input | 2 | Frequency code pins; 2'b11 selects the CD submode |
| fmtSel | input | 3 | Serial format select; 3'd4 is the late-strobe format |
| fsync | input | 1 | Frame sync; the rising edge is the active edge |
| subIn | input | 1 | Serial subcode data, shared with the user-data input |
| sbf | output | 1 | Subcode framing strobe |
| sbc | output | 1 | Subcode bit clock |
| subBit | output | 1 | Most recently sampled subcode symbol |
| subStrobe | output | 1 | One-cycle pulse marking a new `subBit` |
| csBit5 | output | 1 | Channel status bit 5 from the first Q bit |
| csBit2 | output | 1 | Channel status bit 2 from the third Q bit |
| csBit3 | output | 1 | Channel status bit 3 from the fourth Q bit |

## Verification
The assertions assume that `fsync` is already synchronous to `clk`, that `SCK_CLKS` is at least 2, and that `BLOCK_SYMS` is at least 4, so that a block always carries all three Q bits. They also assume that enable is judged from the same sampled inputs that the control uses, so a strobe fall is followed by a bit-clock pulse only if the port stayed enabled. The stimulus drives `fsync`, `subIn`, `fmtSel` and the mode inputs only on falling clock edges. It changes `fmtSel` only between runs of frames, and it spaces frames at 32 cycles except in one deliberate burst at 6 cycles that tests how overlapping frame edges are rejected.

// File: rtl/cdsub_pkg.sv
package cdsub_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STROBE,
    ST_CLKHI,
    ST_CLKLO
  } phase_t;

  typedef struct packed {
    logic capture;
    logic takeFirst;
    logic takeThird;
    logic commit;
  } strobe_t;

endpackage

// File: rtl/cdsub_ctrl.sv
module cdsub_ctrl
  import cdsub_pkg::*;
#(
  parameter int FMT_W      = 3,
  parameter int LATE_FMT   = 4,
  parameter int SCK_CLKS   = 2,
  parameter int HOLD_SBC   = 17,
  parameter int BLOCK_SYMS = 98
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             fsync,
  input  logic [FMT_W-1:0] fmtSel,
  output logic             sbf,
  output logic             sbc,
  output strobe_t          stb
);

  localparam int LONG_CLKS = HOLD_SBC * 2 * SCK_CLKS;
  localparam int TMR_W     = $clog2(LONG_CLKS + 1);
  localparam int SYM_W     = $clog2(BLOCK_SYMS);
  localparam logic [TMR_W-1:0] LONG_LOAD  = TMR_W'(LONG_CLKS - 1);
  localparam logic [TMR_W-1:0] SHORT_LOAD = TMR_W'(SCK_CLKS - 1);
  localparam logic [SYM_W-1:0] LAST_SYM   = SYM_W'(BLOCK_SYMS - 1);
  localparam logic [FMT_W-1:0] LATE_CODE  = FMT_W'(LATE_FMT);

  phase_t           state;
  logic [TMR_W-1:0] tmr;
  logic [SYM_W-1:0] symCnt;
  logic             fsyncQ;
  logic             frameEdge;
  logic             blockStart;
  logic             tmrDone;
  logic [TMR_W-1:0] strobeLoad;

  assign frameEdge  = fsync & ~fsyncQ;
  assign blockStart = (symCnt == '0);
  assign tmrDone    = (tmr == '0);
  assign strobeLoad = blockStart ? LONG_LOAD : SHORT_LOAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      tmr    <= '0;
      symCnt <= '0;
      fsyncQ <= 1'b0;
    end else begin
      fsyncQ <= fsync;
      if (!enable) begin
        state  <= ST_IDLE;
        tmr    <= '0;
        symCnt <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (frameEdge) begin
              if (fmtSel == LATE_CODE) begin
                state <= ST_WAIT;
                tmr   <= SHORT_LOAD;
              end else begin
                state <= ST_STROBE;
                tmr   <= strobeLoad;
              end
            end
          end
          ST_WAIT: begin
            if (tmrDone) begin
              state <= ST_STROBE;
              tmr   <= strobeLoad;
            end else begin
              tmr <= tmr - 1'b1;
            end
          end
          ST_STROBE: begin
            if (tmrDone) begin
              state <= ST_CLKHI;
              tmr   <= SHORT_LOAD;
            end else begin
              tmr <= tmr - 1'b1;
            end
          end
          ST_CLKHI: begin
            if (tmrDone) begin
              state <= ST_CLKLO;
              tmr   <= SHORT_LOAD;
            end else begin
              tmr <= tmr - 1'b1;
            end
          end
          ST_CLKLO: begin
            if (tmrDone) state <= ST_IDLE;
            else         tmr   <= tmr - 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
        if (stb.capture) begin
          symCnt <= (symCnt == LAST_SYM) ? '0 : symCnt + SYM_W'(1);
        end
      end
    end
  end

  always_comb begin
    stb.capture   = enable && (state == ST_STROBE) && tmrDone;
    stb.takeFirst = stb.capture && (symCnt == SYM_W'(0));
    stb.takeThird = stb.capture && (symCnt == SYM_W'(2));
    stb.commit    = stb.capture && (symCnt == SYM_W'(3));
  end

  assign sbf = (state == ST_STROBE);
  assign sbc = (state == ST_CLKHI);

  assert_sbc_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    !(sbf && sbc));

  assert_sbc_follows_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(sbf) && $past(enable)) |-> sbc);

  assert_strobe_min_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(sbf) && enable) |=> sbf);

  assert_normal_start_R3: assert property (@(posedge clk) disable iff (rst)
    (enable && state == ST_IDLE && frameEdge && fmtSel != LATE_CODE) |=> sbf);

  assert_late_start_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && state == ST_IDLE && frameEdge && fmtSel == LATE_CODE) |=> !sbf);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sbf && !sbc));

endmodule

// File: rtl/cdsub_dpath.sv
module cdsub_dpath
  import cdsub_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t stb,
  input  logic    subIn,
  output logic    subBit,
  output logic    subStrobe,
  output logic    csBit5,
  output logic    csBit2,
  output logic    csBit3
);

  logic firstQ;
  logic thirdQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      subBit    <= 1'b0;
      subStrobe <= 1'b0;
      firstQ    <= 1'b0;
      thirdQ    <= 1'b0;
      csBit5    <= 1'b0;
      csBit2    <= 1'b0;
      csBit3    <= 1'b0;
    end else begin
      subStrobe <= stb.capture;
      if (stb.capture)   subBit <= subIn;
      if (stb.takeFirst) firstQ <= subIn;
      if (stb.takeThird) thirdQ <= subIn;
      if (stb.commit) begin
        csBit5 <= firstQ;
        csBit2 <= thirdQ;
        csBit3 <= subIn;
      end
    end
  end

  assert_commit_only_R7: assert property (@(posedge clk) disable iff (rst)
    !stb.commit |=> $stable({csBit5, csBit2, csBit3}));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    subStrobe |=> !subStrobe);

endmodule

// File: rtl/cd_subcode_port.sv
module cd_subcode_port
  import cdsub_pkg::*;
#(
  parameter int FMT_W      = 3,
  parameter int LATE_FMT   = 4,
  parameter int SCK_CLKS   = 2,
  parameter int HOLD_SBC   = 17,
  parameter int BLOCK_SYMS = 98
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             consumerMode,
  input  logic [1:0]       freqCode,
  input  logic [FMT_W-1:0] fmtSel,
  input  logic             fsync,
  input  logic             subIn,
  output logic             sbf,
  output logic             sbc,
  output logic             subBit,
  output logic             subStrobe,
  output logic             csBit5,
  output logic             csBit2,
  output logic             csBit3
);

  logic    portOn;
  strobe_t stb;

  assign portOn = consumerMode && (freqCode == 2'b11);

  cdsub_ctrl #(
    .FMT_W     (FMT_W),
    .LATE_FMT  (LATE_FMT),
    .SCK_CLKS  (SCK_CLKS),
    .HOLD_SBC  (HOLD_SBC),
    .BLOCK_SYMS(BLOCK_SYMS)
  ) ctrlInst (
    .clk   (clk),
    .rst   (rst),
    .enable(portOn),
    .fsync (fsync),
    .fmtSel(fmtSel),
    .sbf   (sbf),
    .sbc   (sbc),
    .stb   (stb)
  );

  cdsub_dpath dpathInst (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .subIn    (subIn),
    .subBit   (subBit),
    .subStrobe(subStrobe),
    .csBit5   (csBit5),
    .csBit2   (csBit2),
    .csBit3   (csBit3)
  );

endmodule

// File: tb/cd_subcode_port_test.sv
module cd_subcode_port_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       consumerMode = 1'b0;
  logic [1:0] freqCode = 2'b00;
  logic [2:0] fmtSel = 3'd0;
  logic       fsync = 1'b0;
  logic       subIn = 1'b0;
  logic       sbf, sbc, subBit, subStrobe, csBit5, csBit2, csBit3;

  always #10 clk = ~clk;

  cd_subcode_port uut (
    .clk(clk), .rst(rst), .consumerMode(consumerMode), .freqCode(freqCode),
    .fmtSel(fmtSel), .fsync(fsync), .subIn(subIn), .sbf(sbf), .sbc(sbc),
    .subBit(subBit), .subStrobe(subStrobe), .csBit5(csBit5), .csBit2(csBit2),
    .csBit3(csBit3)
  );

  int    nChecks = 0;
  int    nFail = 0;
  bit    finished = 1'b0;
  string ovr = "";
  string sbfTag = "R3";
  int    seed = 7;

  bit mBusy, mFsPrev, mSbit, mStb, mCs5, mCs2, mCs3;
  int mK, mD, mP, mSym;
  bit qBits[$];

  task automatic chk(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string pick(string dflt);
    return (ovr != "") ? ovr : dflt;
  endfunction

  // Behavioural reference: frame offset counter, symbol count, Q-bit queue
  always @(posedge clk) begin
    bit en, edgeNow;
    if (rst) begin
      mBusy = 0; mK = 0; mD = 0; mP = 2; mSym = 0; mFsPrev = 0;
      mSbit = 0; mStb = 0; mCs5 = 0; mCs2 = 0; mCs3 = 0;
      qBits.delete();
    end else begin
      en = consumerMode && (freqCode == 2'b11);
      edgeNow = fsync && !mFsPrev;
      mFsPrev = fsync;
      mStb = 0;
      if (!en) begin
        mBusy = 0; mSym = 0;
      end else if (mBusy) begin
        mK++;
        if (mK == mD + mP) begin
          mSbit = subIn; mStb = 1;
          if (mSym == 0) qBits.delete();
          qBits.push_back(subIn);
          if (qBits.size() == 4) begin
            mCs5 = qBits[0]; mCs2 = qBits[2]; mCs3 = qBits[3];
          end
          mSym = (mSym + 1) % 98;
        end
        if (mK == mD + mP + 4) mBusy = 0;
      end else if (edgeNow) begin
        mBusy = 1; mK = 0;
        mD = (fmtSel == 3'd4) ? 2 : 0;
        mP = (mSym == 0) ? 68 : 2;
      end
    end
  end

  always @(posedge clk) begin
    bit eSbf, eSbc;
    string sTag;
    #5;
    if (!finished) begin
      eSbf = mBusy && mK >= mD && mK < mD + mP;
      eSbc = mBusy && mK >= mD + mP && mK < mD + mP + 2;
      if (mBusy && mP == 68) sTag = "R5";
      else if (mBusy && mK >= mD) sTag = "R2";
      else sTag = sbfTag;
      chk(pick(sTag), "sbf", sbf, eSbf);
      chk(pick("R1"), "sbc", sbc, eSbc);
      chk(pick("R6"), "subStrobe", subStrobe, mStb);
      chk(pick("R6"), "subBit", subBit, mSbit);
      chk(pick("R7"), "csBit5", csBit5, mCs5);
      chk(pick("R7"), "csBit2", csBit2, mCs2);
      chk(pick("R7"), "csBit3", csBit3, mCs3);
    end
  end

  task automatic frames(int n, int period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seed = seed * 1103515245 + 12345;
      fsync = 1'b1;
      subIn = seed[16];
      repeat (period / 2) @(negedge clk);
      fsync = 1'b0;
      repeat (period - period / 2 - 1) @(negedge clk);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFail++;
    $display("FAIL R1 watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R9: reset state
    chk("R9", "sbf", sbf, 1'b0);
    chk("R9", "sbc", sbc, 1'b0);
    chk("R9", "csBit5", csBit5, 1'b0);
    chk("R9", "subStrobe", subStrobe, 1'b0);
    rst = 1'b0;
    // R8: wrong mode, then wrong frequency code
    ovr = "R8"; freqCode = 2'b11; consumerMode = 1'b0;
    frames(4, 32);
    consumerMode = 1'b1; freqCode = 2'b01;
    frames(4, 32);
    // R3, R2, R5, R6, R7: normal format across a block boundary
    ovr = ""; freqCode = 2'b11; fmtSel = 3'd0; sbfTag = "R3";
    frames(110, 32);
    // R4: late format across another block boundary
    fmtSel = 3'd4; sbfTag = "R4";
    frames(100, 32);
    // R10: frame edges faster than a frame sequence
    fmtSel = 3'd2; ovr = "R10";
    frames(40, 6);
    // R8: disable mid block, then re-enable (new block start)
    ovr = "R8"; consumerMode = 1'b0;
    frames(3, 32);
    ovr = ""; consumerMode = 1'b1; sbfTag = "R3";
    frames(12, 32);
    @(negedge clk);
    chk("R7", "csBit5 end", csBit5, mCs5);
    chk("R7", "csBit2 end", csBit2, mCs2);
    chk("R7", "csBit3 end", csBit3, mCs3);
    // R9: reset clears latched bits
    ovr = "R9"; rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "csBit5", csBit5, 1'b0);
    chk("R9", "csBit2", csBit2, 1'b0);
    chk("R9", "csBit3", csBit3, 1'b0);
    chk("R9", "subBit", subBit, 1'b0);
    summary();
  end

endmodule